// File: doc/BRIEF.md
# Multicycle Instruction Interpreter Core

This block is a minimal processor core that steps through a fetch, decode and execute loop. It reads one 32-bit instruction per loop from a word-addressed synchronous memory, registers it, and advances the program counter by one word before the instruction is classified. It acts on two kinds of instruction. An escape opcode carries a 12-bit sub-opcode that can select a three-register add. A trap opcode stops the core. Every other encoding is fetched, decoded and then dropped.

The core takes three cycles per instruction: fetch, decode and execute. Memory read data returns one cycle after the address. A trap parks the controller in a halt state until reset, and the halted flag and program counter then stay frozen. A 32-entry register file sits in the core. A debug port reads any entry combinationally. It can also write an entry, but only while the core is held in reset or halted, so a test harness can seed operands and collect results around a run.

Top module: `interp_core`

## Requirements
- R1: While reset is high at a clock edge, the program counter, `mem_addr` and `halted` become 0 after that edge. Reset does not change the register file contents.
- R2: Instruction k after reset is fetched three cycles after instruction k-1. `mem_addr` equals k during its fetch cycle, and the program counter becomes k+1 at the end of that cycle.
- R3: Instruction fields are opcode = bits 31..27, destination = bits 26..22, first source = bits 21..17, second source = bits 16..12 and sub-opcode = bits 11..0. Opcode 31 with sub-opcode 10 writes destination = first source + second source at the end of the instruction's third cycle.
- R4: The add wraps modulo 2^32.
- R5: Opcode 19 raises `halted` at the end of the trap's third cycle. The program counter then holds the trap address + 1, and no later instruction executes.
- R6: Any opcode other than 31 or 19, and any sub-opcode other than 10 under opcode 31, leaves the register file and `halted` unchanged.
- R7: Once halted, `halted`, `pc` and `mem_addr` stay constant until reset. After reset the core restarts from address 0 with the same timing.
- R8: `dbg_rdata` shows the entry selected by `dbg_addr` with no delay. `dbg_we` writes `dbg_wdata` at the clock edge only while reset is high or the core is halted, and is ignored while the core is running.
- R9: An add reads its sources as they stood before its own write, so a destination that is also a source yields the sum of the old values. A later add sees the results of earlier adds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Word address for instruction fetch |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a trap has executed |
| pc | output | AW | Program counter |
| dbg_addr | input | 5 | Register file debug entry select |
| dbg_rdata | output | 32 | Register file debug read data |
| dbg_we | input | 1 | Debug write strobe, honoured only in reset or halt |
| dbg_wdata | input | 32 | Debug write data |

## Verification
Single add programs are driven from a vector table. The table covers distinct registers, register 0 as an ordinary entry, a destination equal to its source, and two carry-out cases. Together these separate correct field extraction from swapped or shifted fields, and wrapping from saturation. A program of mixed non-executing encodings, including the add sub-opcode under a foreign opcode and foreign sub-opcodes under the escape, shows that only the exact escape pair writes. A dependent chain with an add placed after the trap shows read-before-write ordering and that the trap stops execution. A run with a debug write pulsed mid-program, followed by a write while halted, a reset and a rerun, tells the write gating apart from the restart behaviour and shows that reset keeps the registers.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX   = $clog2(NREG);
    localparam int OPW    = 5;
    localparam int SUBW   = 12;

    localparam logic [OPW-1:0]  OP_ESCAPE = 5'd31;
    localparam logic [OPW-1:0]  OP_TRAP   = 5'd19;
    localparam logic [SUBW-1:0] SUB_ADD   = 12'd10;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALT   = 2'd3
    } state_t;

    // field layout, most significant first
    typedef struct packed {
        logic [OPW-1:0]  opcode;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs1;
        logic [RIDX-1:0] rs2;
        logic [SUBW-1:0] sub;
    } instr_t;

    typedef enum logic [1:0] {
        K_NOP  = 2'd0,
        K_ADD  = 2'd1,
        K_TRAP = 2'd2
    } kind_t;

    function automatic kind_t classify(instr_t i);
        kind_t k;
        k = K_NOP;
        if (i.opcode == OP_TRAP)
            k = K_TRAP;
        else if (i.opcode == OP_ESCAPE && i.sub == SUB_ADD)
            k = K_ADD;
        return k;
    endfunction

endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [XLEN-1:0]     mem_rdata,
    input  logic                trap_now,
    output state_t              state,
    output logic [AW-1:0]       pc,
    output instr_t              ir
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            pc    <= '0;
            ir    <= '0;
        end else begin
            case (state)
                ST_FETCH: begin
                    pc    <= pc + AW'(1);
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    ir    <= instr_t'(mem_rdata);
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    state <= trap_now ? ST_HALT : ST_FETCH;
                end
                ST_HALT: begin
                    state <= ST_HALT;
                end
                default: state <= ST_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/mc_exec.sv
module mc_exec
    import mc_pkg::*;
(
    input  state_t              state,
    input  instr_t              ir,
    input  logic [XLEN-1:0]     src_a_val,
    input  logic [XLEN-1:0]     src_b_val,
    output logic [RIDX-1:0]     src_a_sel,
    output logic [RIDX-1:0]     src_b_sel,
    output logic                wr_en,
    output logic [RIDX-1:0]     wr_sel,
    output logic [XLEN-1:0]     wr_val,
    output logic                trap_now
);

    kind_t kind;

    always_comb begin
        kind      = classify(ir);
        src_a_sel = ir.rs1;
        src_b_sel = ir.rs2;
        wr_sel    = ir.rd;
        wr_val    = src_a_val + src_b_val;
        wr_en     = (state == ST_EXEC) && (kind == K_ADD);
        trap_now  = (kind == K_TRAP);
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
(
    input  logic                clk,
    input  logic                core_we,
    input  logic [RIDX-1:0]     core_sel,
    input  logic [XLEN-1:0]     core_val,
    input  logic                dbg_allow,
    input  logic                dbg_we,
    input  logic [RIDX-1:0]     dbg_sel,
    input  logic [XLEN-1:0]     dbg_val,
    input  logic [RIDX-1:0]     rsel_a,
    input  logic [RIDX-1:0]     rsel_b,
    output logic [XLEN-1:0]     rval_a,
    output logic [XLEN-1:0]     rval_b,
    output logic [XLEN-1:0]     dbg_rval
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (core_we)
            regs[core_sel] <= core_val;
        else if (dbg_allow && dbg_we)
            regs[dbg_sel] <= dbg_val;
    end

    assign rval_a   = regs[rsel_a];
    assign rval_b   = regs[rsel_b];
    assign dbg_rval = regs[dbg_sel];

endmodule

// File: rtl/interp_core.sv
module interp_core
    import mc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    output logic [AW-1:0]       mem_addr,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                halted,
    output logic [AW-1:0]       pc,
    input  logic [RIDX-1:0]     dbg_addr,
    output logic [XLEN-1:0]     dbg_rdata,
    input  logic                dbg_we,
    input  logic [XLEN-1:0]     dbg_wdata
);

    state_t          st;
    logic [AW-1:0]   pc_q;
    instr_t          ir_q;
    logic            trap_now;
    logic [RIDX-1:0] sel_a, sel_b, wsel;
    logic [XLEN-1:0] val_a, val_b, wval;
    logic            core_we;

    mc_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .trap_now  (trap_now),
        .state     (st),
        .pc        (pc_q),
        .ir        (ir_q)
    );

    mc_exec u_exec (
        .state     (st),
        .ir        (ir_q),
        .src_a_val (val_a),
        .src_b_val (val_b),
        .src_a_sel (sel_a),
        .src_b_sel (sel_b),
        .wr_en     (core_we),
        .wr_sel    (wsel),
        .wr_val    (wval),
        .trap_now  (trap_now)
    );

    mc_regfile u_rf (
        .clk       (clk),
        .core_we   (core_we),
        .core_sel  (wsel),
        .core_val  (wval),
        .dbg_allow (rst || halted),
        .dbg_we    (dbg_we),
        .dbg_sel   (dbg_addr),
        .dbg_val   (dbg_wdata),
        .rsel_a    (sel_a),
        .rsel_b    (sel_b),
        .rval_a    (val_a),
        .rval_b    (val_b),
        .dbg_rval  (dbg_rdata)
    );

    assign halted   = (st == ST_HALT);
    assign pc       = pc_q;
    assign mem_addr = pc_q;

endmodule

// File: rtl/interp_core_chk.sv
module interp_core_chk
    import mc_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input state_t        state,
    input logic [AW-1:0] pc,
    input logic          halted,
    input instr_t        ir,
    input logic          rf_we
);

    logic rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            AST_RESET_STATE: assert (pc == '0 && !halted && state == ST_FETCH); // R1
        end
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (pc == AW'($past(pc) + AW'(1)))); // R2

    AST_WRITE_ONLY_ADD: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (state == ST_EXEC && ir.opcode == OP_ESCAPE && ir.sub == SUB_ADD)); // R3

    AST_TRAP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir.opcode == OP_TRAP) |=> halted); // R5

    AST_NO_STRAY_HALT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir.opcode != OP_TRAP) |=> !halted); // R6

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc))); // R7

endmodule

bind interp_core interp_core_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .state  (st),
    .pc     (pc_q),
    .halted (halted),
    .ir     (ir_q),
    .rf_we  (core_we)
);

// File: tb/sim_interp_core.sv
module sim_interp_core;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int MEMW       = 64;
    localparam logic [31:0] TRAP_W = {5'd19, 27'd0};

    logic        clk = 1'b0;
    logic        rst;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        halted;
    logic [AW-1:0] pc;
    logic [4:0]  dbg_addr;
    logic [31:0] dbg_rdata;
    logic        dbg_we;
    logic [31:0] dbg_wdata;

    logic [31:0] mem [MEMW];
    int n_checks = 0;
    int n_errors = 0;
    logic [4:0]  pulse_reg;
    logic [31:0] pulse_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) mem_rdata <= mem[mem_addr[5:0]];

    interp_core #(.AW(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .pc        (pc),
        .dbg_addr  (dbg_addr),
        .dbg_rdata (dbg_rdata),
        .dbg_we    (dbg_we),
        .dbg_wdata (dbg_wdata)
    );

    typedef struct packed {
        logic [4:0]  rd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] va;
        logic [31:0] vb;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{5'd3,  5'd1,  5'd2,  32'd5,         32'd7},
        '{5'd31, 5'd30, 5'd29, 32'hFFFF_FFFF, 32'd2},
        '{5'd0,  5'd0,  5'd5,  32'd100,       32'd23},
        '{5'd4,  5'd4,  5'd4,  32'd9,         32'h4000_0000},
        '{5'd9,  5'd9,  5'd10, 32'h1234_5678, 32'h1111_1111},
        '{5'd17, 5'd16, 5'd8,  32'h8000_0000, 32'h8000_0000}
    };

    function automatic logic [31:0] f_word(logic [4:0] op, logic [4:0] d,
                                            logic [4:0] a, logic [4:0] b,
                                            logic [11:0] s);
        return {op, d, a, b, s};
    endfunction

    function automatic logic [31:0] f_add(logic [4:0] d, logic [4:0] a, logic [4:0] b);
        return {5'd31, d, a, b, 12'd10};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEMW; i++) mem[i] = '0;
    endtask

    task automatic dbg_write(logic [4:0] a, logic [31:0] v);
        @(negedge clk);
        dbg_addr  = a;
        dbg_wdata = v;
        dbg_we    = 1'b1;
        @(negedge clk);
        dbg_we    = 1'b0;
    endtask

    task automatic rd_reg(logic [4:0] a, output logic [31:0] v);
        dbg_addr = a;
        #1;
        v = dbg_rdata;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // release reset and run until the trap at index t has retired
    task automatic run_prog(int t, int pulse_at);
        @(negedge clk);
        rst = 1'b0;
        for (int e = 0; e < 3*t + 3; e++) begin
            if (e % 3 == 0)
                chk($sformatf("R2 fetch address of instr %0d", e/3), 32'(mem_addr), 32'(e/3));
            if (e == 3*t + 2)
                chk("R5 not halted before trap retires", 32'(halted), 32'd0);
            if (e == pulse_at) begin
                dbg_addr  = pulse_reg;
                dbg_wdata = pulse_val;
                dbg_we    = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            dbg_we = 1'b0;
        end
        chk("R5 halted after trap", 32'(halted), 32'd1);
        chk("R5 pc after trap", 32'(pc), 32'(t + 1));
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk("R7 halted holds", 32'(halted), 32'd1);
            chk("R7 mem_addr frozen", 32'(mem_addr), 32'(t + 1));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] model [32];
        rst       = 1'b1;
        dbg_we    = 1'b0;
        dbg_addr  = '0;
        dbg_wdata = '0;
        pulse_reg = '0;
        pulse_val = '0;
        clear_mem();
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 pc in reset", 32'(pc), 32'd0);
        chk("R1 halted in reset", 32'(halted), 32'd0);
        chk("R1 mem_addr in reset", 32'(mem_addr), 32'd0);

        // vector table of single-add programs
        for (int n = 0; n < NVEC; n++) begin
            clear_mem();
            mem[0] = f_add(VECS[n].rd, VECS[n].ra, VECS[n].rb);
            mem[1] = TRAP_W;
            dbg_write(VECS[n].ra, VECS[n].va);
            dbg_write(VECS[n].rb, VECS[n].vb);
            model[VECS[n].ra] = VECS[n].va;
            model[VECS[n].rb] = VECS[n].vb;
            rd_reg(VECS[n].ra, v);
            chk("R8 debug write during reset", v, model[VECS[n].ra]);
            run_prog(1, -1);
            rd_reg(VECS[n].rd, v);
            chk($sformatf("R3 R4 R9 add vector %0d", n), v,
                model[VECS[n].ra] + model[VECS[n].rb]);
            enter_reset();
        end

        // R6 non-executing encodings
        clear_mem();
        dbg_write(5'd1, 32'h11);
        dbg_write(5'd2, 32'h22);
        dbg_write(5'd3, 32'h33);
        mem[0] = f_word(5'd5,  5'd1, 5'd2, 5'd3, 12'd10);
        mem[1] = f_word(5'd31, 5'd1, 5'd2, 5'd3, 12'd11);
        mem[2] = f_word(5'd31, 5'd1, 5'd2, 5'd3, 12'd0);
        mem[3] = f_word(5'd30, 5'd1, 5'd2, 5'd3, 12'd10);
        mem[4] = TRAP_W;
        run_prog(4, -1);
        rd_reg(5'd1, v); chk("R6 r1 untouched by no-ops", v, 32'h11);
        rd_reg(5'd2, v); chk("R6 r2 untouched by no-ops", v, 32'h22);
        rd_reg(5'd3, v); chk("R6 r3 untouched by no-ops", v, 32'h33);
        enter_reset();

        // R9 dependent chain, R5 nothing after the trap
        clear_mem();
        dbg_write(5'd1, 32'd3);
        dbg_write(5'd2, 32'd4);
        mem[0] = f_add(5'd3, 5'd1, 5'd2);
        mem[1] = f_add(5'd3, 5'd3, 5'd3);
        mem[2] = f_add(5'd5, 5'd3, 5'd1);
        mem[3] = TRAP_W;
        mem[4] = f_add(5'd1, 5'd2, 5'd2);
        run_prog(3, -1);
        rd_reg(5'd3, v); chk("R9 chained self add", v, 32'd14);
        rd_reg(5'd5, v); chk("R9 chained dependent add", v, 32'd17);
        rd_reg(5'd1, v); chk("R5 instruction after trap not run", v, 32'd3);
        enter_reset();

        // R8 debug write gating, R1 registers kept over reset, R7 restart
        clear_mem();
        dbg_write(5'd20, 32'h1111);
        mem[6] = TRAP_W;
        pulse_reg = 5'd20;
        pulse_val = 32'hDEAD;
        run_prog(6, 4);
        rd_reg(5'd20, v); chk("R8 debug write ignored while running", v, 32'h1111);
        dbg_write(5'd20, 32'h2222);
        rd_reg(5'd20, v); chk("R8 debug write while halted", v, 32'h2222);
        enter_reset();
        chk("R7 halted cleared by reset", 32'(halted), 32'd0);
        chk("R7 pc cleared by reset", 32'(pc), 32'd0);
        rd_reg(5'd20, v); chk("R1 register kept over reset", v, 32'h2222);
        run_prog(6, -1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule